// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two single-precision (binary32) values, a left operand and a right operand, and produces a four-bit condition code together with an invalid-operation flag. The ordering is worked out directly on the packed encodings. Each operand is classified as a NaN or not and as a zero magnitude or not. Two ordered values are then placed by an integer compare of their bit patterns, corrected for sign. No field is unpacked and no subtraction is performed.

Two controls shape each request. A strict control makes a quiet NaN raise the invalid flag as well as a signalling one. A zero control replaces the right operand with positive zero, which gives the compare-with-zero forms. The compare logic is combinational. The result goes through one register stage and is marked by a valid strobe one cycle after the request. Writing the flags into any status register is left to the surrounding logic.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `res_flags` and `res_invalid` are 0 until the first accepted request.
- R2: A request presented with `req_valid` high at a rising edge produces `res_valid` high after that edge for exactly one cycle. `res_flags` and `res_invalid` change only on an accepted request and hold their value otherwise.
- R3: `res_flags` is packed as {N,Z,C,V}, with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. Equal operands give 4'b0110. Operands are equal when their bit patterns match, or when both have zero magnitude, so +0 equals -0.
- R4: When the left operand is below the right operand, the code is 4'b1000.
- R5: When the left operand is above the right operand, the code is 4'b0010. With differing signs the negative operand is the smaller one. With equal signs the magnitude bits are compared as an unsigned integer, and the sense is inverted when both operands are negative.
- R6: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. A NaN in either operand gives the unordered code 4'b0011. Infinities (exponent all ones, fraction zero) are ordered normally.
- R7: A NaN whose bit 22 is 0 is signalling. If either operand is a signalling NaN, `res_invalid` is 1, whatever the strict control says.
- R8: With `strict_nan` = 1, a quiet NaN (bit 22 = 1) in either operand also sets `res_invalid`. With no NaN present, `res_invalid` is 0.
- R9: With `cmp_zero` = 1, the right operand is taken as +0 (all zero bits) and `opnd_m` has no effect on the result.
- R10: With no NaN present, exactly one of the three ordering codes (4'b1000, 4'b0110, 4'b0010) is produced, and V is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; operands and controls are sampled when it is high |
| opnd_d | input | 32 | Left operand, binary32 encoding |
| opnd_m | input | 32 | Right operand, binary32 encoding |
| strict_nan | input | 1 | 1: quiet NaNs also raise invalid |
| cmp_zero | input | 1 | 1: right operand replaced by +0 |
| res_valid | output | 1 | High for one cycle when a result is presented |
| res_flags | output | 4 | Condition code {N,Z,C,V} |
| res_invalid | output | 1 | Invalid-operation flag |

## Verification
Each fault that can occur in this block reaches the ports one cycle after the request that exposes it. There is only one register stage between the classification and compare logic and the outputs. A mistake in the NaN classifier shows up as an ordered code where 4'b0011 belongs, or as a wrong invalid bit. A mistake in the sign correction flips less-than and greater-than only for pairs of negative operands, so the directed cases include those pairs. A missing hold on the result register shows up as flag movement on cycles with no request, so the bench keeps changing the operands while the strobe is low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Position of each condition bit inside the four-bit result
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  localparam logic [3:0] CODE_LT = 4'b1000;
  localparam logic [3:0] CODE_EQ = 4'b0110;
  localparam logic [3:0] CODE_GT = 4'b0010;
  localparam logic [3:0] CODE_UN = 4'b0011;

  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } order_t;

  // Map an ordering outcome onto its fixed condition code
  function automatic logic [3:0] code_of(input order_t o);
    logic [3:0] f;
    f = '0;
    unique case (o)
      ORD_LT: f[FLAG_N] = 1'b1;
      ORD_EQ: begin f[FLAG_Z] = 1'b1; f[FLAG_C] = 1'b1; end
      ORD_GT: f[FLAG_C] = 1'b1;
      ORD_UN: begin f[FLAG_C] = 1'b1; f[FLAG_V] = 1'b1; end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  input  logic                  strict,
  output logic                  is_nan,
  output logic                  is_sig,
  output logic                  zero_mag,
  output logic                  raise
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int QBIT  = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = op[W-2 -: EXP_W];
  assign frac_f = op[FRAC_W-1:0];

  // All-ones exponent with a non-zero fraction
  function automatic logic nan_test(input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    return (&e) && (|f);
  endfunction

  // Magnitude field entirely clear (either sign)
  function automatic logic zero_test(input logic [W-2:0] mag);
    return ~|mag;
  endfunction

  always_comb begin
    is_nan   = nan_test(exp_f, frac_f);
    is_sig   = is_nan && !frac_f[QBIT];
    zero_mag = zero_test(op[W-2:0]);
    raise    = is_nan && (strict || !frac_f[QBIT]);
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         a_zero,
  input  logic         b_zero,
  output order_t       ord
);

  // Ordering of two non-NaN encodings without unpacking
  function automatic order_t order_of(input logic [W-1:0] x, input logic [W-1:0] y,
                                      input logic xz, input logic yz);
    logic below;
    if (x == y || (xz && yz)) begin
      return ORD_EQ;
    end
    if (x[W-1] != y[W-1]) begin
      return x[W-1] ? ORD_LT : ORD_GT;
    end
    below = (x[W-2:0] < y[W-2:0]);
    return (below ^ x[W-1]) ? ORD_LT : ORD_GT;
  endfunction

  assign ord = order_of(a, b, a_zero, b_zero);

endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              inv_in,
  output logic              valid_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic              inv_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flags_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        flags_q <= flags_in;
        inv_q   <= inv_in;
      end
    end
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [EXP_W+FRAC_W:0] opnd_d,
  input  logic [EXP_W+FRAC_W:0] opnd_m,
  input  logic                  strict_nan,
  input  logic                  cmp_zero,
  output logic                  res_valid,
  output logic [3:0]            res_flags,
  output logic                  res_invalid
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][W-1:0] ops;
  logic [N_OPS-1:0]        nan_v, sig_v, zero_v, raise_v;

  // Index 0 is the left operand, index 1 the (possibly zeroed) right operand
  assign ops[0] = opnd_d;
  assign ops[1] = cmp_zero ? '0 : opnd_m;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op       (ops[gi]),
      .strict   (strict_nan),
      .is_nan   (nan_v[gi]),
      .is_sig   (sig_v[gi]),
      .zero_mag (zero_v[gi]),
      .raise    (raise_v[gi])
    );
  end

  // Named events for the checker
  logic   nan_d, nan_m, nan_any, sig_any, raise_any;
  order_t ord_raw, ord_sel;
  logic [3:0] flags_next;

  assign nan_d     = nan_v[0];
  assign nan_m     = nan_v[1];
  assign nan_any   = |nan_v;
  assign sig_any   = |sig_v;
  assign raise_any = |raise_v;

  fcmp_order #(.W(W)) u_ord (
    .a      (ops[0]),
    .b      (ops[1]),
    .a_zero (zero_v[0]),
    .b_zero (zero_v[1]),
    .ord    (ord_raw)
  );

  assign ord_sel    = nan_any ? ORD_UN : ord_raw;
  assign flags_next = code_of(ord_sel);

  fcmp_flag_reg #(.FLAG_W(4)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_valid),
    .flags_in (flags_next),
    .inv_in   (raise_any),
    .valid_q  (res_valid),
    .flags_q  (res_flags),
    .inv_q    (res_invalid)
  );

endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic [W-1:0] opnd_d,
  input logic         cmp_zero,
  input logic         res_valid,
  input logic [3:0]   res_flags,
  input logic         res_invalid,
  input logic         nan_d,
  input logic         nan_m,
  input logic         sig_any
);

  assert_strobe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_strobe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_flags) && $stable(res_invalid)));

  assert_unordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (nan_d || nan_m)) |=> res_flags == 4'b0011);

  assert_signal_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sig_any) |=> res_invalid);

  assert_no_nan_no_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !nan_d && !nan_m) |=> !res_invalid);

  assert_zero_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cmp_zero && !nan_d && opnd_d[W-2:0] == '0) |=> res_flags == 4'b0110);

  assert_one_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !nan_d && !nan_m) |=>
      (res_flags == 4'b1000 || res_flags == 4'b0110 || res_flags == 4'b0010));

endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .opnd_d      (opnd_d),
  .cmp_zero    (cmp_zero),
  .res_valid   (res_valid),
  .res_flags   (res_flags),
  .res_invalid (res_invalid),
  .nan_d       (nan_d),
  .nan_m       (nan_m),
  .sig_any     (sig_any)
);

// File: tb/fcmp_flag_unit_tb.sv
`timescale 1ns/1ps
module fcmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] opnd_d = '0;
  logic [31:0] opnd_m = '0;
  logic        strict_nan = 1'b0;
  logic        cmp_zero = 1'b0;
  logic        res_valid;
  logic [3:0]  res_flags;
  logic        res_invalid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcmp_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .opnd_d(opnd_d), .opnd_m(opnd_m), .strict_nan(strict_nan), .cmp_zero(cmp_zero),
    .res_valid(res_valid), .res_flags(res_flags), .res_invalid(res_invalid)
  );

  // Bench's own model: map encodings onto a monotone unsigned key
  function automatic logic [32:0] ref_key(input logic [31:0] x);
    if (x[30:0] == 31'd0) return 33'h1_0000_0000;
    if (x[31]) return {1'b0, ~x};
    return {1'b1, x};
  endfunction

  function automatic logic [4:0] ref_model(input logic [31:0] d, input logic [31:0] m,
                                           input logic zm, input logic st);
    logic [31:0] mm;
    logic dn, mn, inv;
    mm = zm ? 32'd0 : m;
    dn = (d[30:23] == 8'hFF) && (d[22:0] != 0);
    mn = (mm[30:23] == 8'hFF) && (mm[22:0] != 0);
    inv = (dn && (st || !d[22])) || (mn && (st || !mm[22]));
    if (dn || mn) return {4'b0011, inv};
    if (ref_key(d) < ref_key(mm)) return {4'b1000, 1'b0};
    if (ref_key(d) > ref_key(mm)) return {4'b0010, 1'b0};
    return {4'b0110, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one request, check flags and invalid after the capturing edge
  task automatic run_one(input logic [31:0] d, input logic [31:0] m, input logic zm,
                         input logic st, input string req);
    logic [4:0] e;
    e = ref_model(d, m, zm, st);
    @(negedge clk);
    opnd_d = d; opnd_m = m; cmp_zero = zm; strict_nan = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == 1'b1, {req, " valid"}, {31'd0, res_valid}, 32'd1);
    check(res_flags == e[4:1], {req, " flags"}, {28'd0, res_flags}, {28'd0, e[4:1]});
    check(res_invalid == e[0], {req, " invalid"}, {31'd0, res_invalid}, {31'd0, e[0]});
  endtask

  task automatic t_reset_R1();
    check(res_valid == 1'b0, "R1 valid", {31'd0, res_valid}, 32'd0);
    check(res_flags == 4'd0, "R1 flags", {28'd0, res_flags}, 32'd0);
    check(res_invalid == 1'b0, "R1 invalid", {31'd0, res_invalid}, 32'd0);
  endtask

  task automatic t_equal_R3();
    run_one(32'h3F80_0000, 32'h3F80_0000, 0, 0, "R3 1.0==1.0");
    run_one(32'h0000_0000, 32'h8000_0000, 0, 0, "R3 +0==-0");
    run_one(32'hC2C8_0000, 32'hC2C8_0000, 0, 1, "R3 neg equal");
    run_one(32'h7F80_0000, 32'h7F80_0000, 0, 1, "R6 inf==inf");
  endtask

  task automatic t_less_R4();
    run_one(32'h3F80_0000, 32'h4000_0000, 0, 0, "R4 1<2");
    run_one(32'hBF80_0000, 32'h3F80_0000, 0, 0, "R4 -1<1");
    run_one(32'hC000_0000, 32'hBF80_0000, 0, 0, "R4 -2<-1");
    run_one(32'h8000_0000, 32'h0000_0001, 0, 0, "R4 -0<denorm");
    run_one(32'hFF80_0000, 32'hFF7F_FFFF, 0, 0, "R6 -inf<-max");
  endtask

  task automatic t_greater_R5();
    run_one(32'h4000_0000, 32'h3F80_0000, 0, 0, "R5 2>1");
    run_one(32'h3F80_0000, 32'hBF80_0000, 0, 0, "R5 1>-1");
    run_one(32'hBF80_0000, 32'hC000_0000, 0, 0, "R5 -1>-2");
    run_one(32'h7F80_0000, 32'h7F7F_FFFF, 0, 0, "R6 inf>max");
  endtask

  task automatic t_nan_R6_R7();
    run_one(32'h7FC0_0000, 32'h3F80_0000, 0, 0, "R6 qnan d");
    run_one(32'h3F80_0000, 32'hFFC0_0001, 0, 0, "R6 qnan m");
    run_one(32'h7F80_0001, 32'h3F80_0000, 0, 0, "R7 snan d");
    run_one(32'h0000_0000, 32'hFFA0_0000, 0, 0, "R7 snan m");
    run_one(32'h7F80_0001, 32'h7FC0_0000, 0, 1, "R7 snan strict");
  endtask

  task automatic t_strict_R8();
    run_one(32'h7FC0_0000, 32'h3F80_0000, 0, 1, "R8 qnan strict d");
    run_one(32'h3F80_0000, 32'h7FFF_FFFF, 0, 1, "R8 qnan strict m");
    run_one(32'h4000_0000, 32'h3F80_0000, 0, 1, "R8 no nan strict");
  endtask

  task automatic t_zero_R9();
    run_one(32'h3F80_0000, 32'hFFC0_0000, 1, 1, "R9 pos vs zero, m nan ignored");
    run_one(32'hBF80_0000, 32'h3F80_0000, 1, 0, "R9 neg vs zero");
    run_one(32'h8000_0000, 32'h7F80_0001, 1, 0, "R9 -0 vs zero");
    run_one(32'h7F80_0001, 32'h0000_0000, 1, 0, "R9 snan vs zero");
  endtask

  task automatic t_hold_R2();
    logic [3:0] f0;
    logic i0;
    run_one(32'hBF80_0000, 32'h3F80_0000, 0, 0, "R2 setup");
    f0 = res_flags; i0 = res_invalid;
    for (int k = 0; k < 4; k++) begin
      opnd_d = 32'h7F80_0001; opnd_m = 32'h0; strict_nan = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R2 strobe low", {31'd0, res_valid}, 32'd0);
      check(res_flags == f0 && res_invalid == i0, "R2 hold",
            {27'd0, res_flags, res_invalid}, {27'd0, f0, i0});
    end
  endtask

  task automatic t_sweep_R10();
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h8000_0000; vals[2] = 32'h3F80_0000;
    vals[3] = 32'hBF80_0000; vals[4] = 32'h0000_0001; vals[5] = 32'h807F_FFFF;
    vals[6] = 32'h7F80_0000; vals[7] = 32'hFF80_0000;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        run_one(vals[a], vals[b], 0, b[0], "R10 sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_equal_R3();
    t_less_R4();
    t_greater_R5();
    t_nan_R6_R7();
    t_strict_R8();
    t_zero_R9();
    t_hold_R2();
    t_sweep_R10();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule